// File: doc/BRIEF.md
# Three-Lane Green-Light Selector

This block decides which of three parallel traffic lanes is shown a green light. One lane is the priority lane and is served whenever a car waits in it. The two side lanes, left and right, are served only when the priority lane is empty. When both side lanes have cars, an external alternation input decides which of the two side lanes goes green.

Each of the four inputs is asynchronous to the clock. Each input passes through a two-flop synchronizer. The lane decision is pure combinational logic, and the three light outputs are registered. A sensor change therefore reaches the lights after a fixed three clock cycles. A synchronous, active-high reset clears the synchronizers and turns every light red.

Top module: `lane_green_sel`

## Requirements
- R1: While `rst` is 1 at a rising clock edge, all three light outputs become 0 (red) after that edge.
- R2: When `prio_car` is 1, `prio_green` is 1 and both `left_green` and `right_green` are 0, whatever the other inputs are.
- R3: When `prio_car` is 0, `left_car` is 1 and `right_car` is 0, `left_green` is 1.
- R4: When `prio_car` is 0, `right_car` is 1 and `left_car` is 0, `right_green` is 1.
- R5: When `prio_car` is 0 and both side sensors are 1, `left_green` is 1 if `alt_left` is 1, and `right_green` is 1 if `alt_left` is 0.
- R6: At most one of the three lights is 1 in any cycle.
- R7: A light that R2 to R5 do not turn green is 0. With no car present, all three lights are 0.
- R8: A change on the inputs, applied between clock edges, appears on the lights after the third rising edge and not after the second.
- R9: `alt_left` has no effect on the lights unless `prio_car` is 0 and both side sensors are 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| prio_car | input | 1 | Car present in the priority lane (1 = present) |
| left_car | input | 1 | Car present in the left lane (1 = present) |
| right_car | input | 1 | Car present in the right lane (1 = present) |
| alt_left | input | 1 | Side-lane alternation: 1 favours left, 0 favours right |
| prio_green | output | 1 | Priority lane light (1 = green, 0 = red) |
| left_green | output | 1 | Left lane light (1 = green, 0 = red) |
| right_green | output | 1 | Right lane light (1 = green, 0 = red) |

## Verification
The priority override and the side-lane alternation can act on the same input word. This happens when all three sensors are 1 and `alt_left` toggles. The bench provokes this by applying every one of the sixteen input combinations in sequence. In the cases with the priority sensor set, it then flips `alt_left` and judges that only the priority light is green and that the lights do not move. The bench also asserts reset while a new input word is still in the synchronizer. It judges that the lights go red at once and that the new word reaches the lights only three edges after reset is released.

// File: rtl/lane_green_sel.sv
module lane_green_sel #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic prio_car,
  input  logic left_car,
  input  logic right_car,
  input  logic alt_left,
  output logic prio_green,
  output logic left_green,
  output logic right_green
);

  localparam int NIN = 4;

  logic [NIN-1:0] sync_q [SYNC_STAGES];
  logic [NIN-1:0] seen;
  logic s_prio, s_left, s_right, s_alt;
  logic nx_prio, nx_left, nx_right;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= '0;
    end else begin
      sync_q[0] <= {alt_left, right_car, left_car, prio_car};
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
    end
  end

  assign seen    = sync_q[SYNC_STAGES-1];
  assign s_prio  = seen[0];
  assign s_left  = seen[1];
  assign s_right = seen[2];
  assign s_alt   = seen[3];

  assign nx_prio  = s_prio;
  assign nx_left  = !s_prio && s_left  && (!s_right || s_alt);
  assign nx_right = !s_prio && s_right && (!s_left  || !s_alt);

  always_ff @(posedge clk) begin
    if (rst) begin
      prio_green  <= 1'b0;
      left_green  <= 1'b0;
      right_green <= 1'b0;
    end else begin
      prio_green  <= nx_prio;
      left_green  <= nx_left;
      right_green <= nx_right;
    end
  end

endmodule

// File: rtl/lane_green_sel_chk.sv
module lane_green_sel_chk (
  input logic clk,
  input logic rst,
  input logic prio_car,
  input logic left_car,
  input logic right_car,
  input logic alt_left,
  input logic prio_green,
  input logic left_green,
  input logic right_green
);

  logic [1:0] warm_cnt;
  logic       warm;

  always_ff @(posedge clk) begin
    if (rst) warm_cnt <= '0;
    else if (warm_cnt != 2'd3) warm_cnt <= warm_cnt + 2'd1;
  end
  assign warm = (warm_cnt == 2'd3);

  AST_ONE_GREEN: assert property (@(posedge clk) disable iff (rst)
    $onehot0({prio_green, left_green, right_green})); // R6

  AST_RESET_RED: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !prio_green && !left_green && !right_green); // R1

  AST_PRIO_WINS: assert property (@(posedge clk) disable iff (rst)
    warm && $past(prio_car, 3) |-> prio_green && !left_green && !right_green); // R2

  AST_LEFT_ALONE: assert property (@(posedge clk) disable iff (rst)
    warm && !$past(prio_car, 3) && $past(left_car, 3) && !$past(right_car, 3)
    |-> left_green); // R3

  AST_RIGHT_ALONE: assert property (@(posedge clk) disable iff (rst)
    warm && !$past(prio_car, 3) && $past(right_car, 3) && !$past(left_car, 3)
    |-> right_green); // R4

  AST_ALTERNATE: assert property (@(posedge clk) disable iff (rst)
    warm && !$past(prio_car, 3) && $past(left_car, 3) && $past(right_car, 3)
    |-> (left_green == $past(alt_left, 3)) && (right_green == !$past(alt_left, 3))); // R5

  AST_EMPTY_RED: assert property (@(posedge clk) disable iff (rst)
    warm && !$past(prio_car, 3) && !$past(left_car, 3) && !$past(right_car, 3)
    |-> !prio_green && !left_green && !right_green); // R7

endmodule

bind lane_green_sel lane_green_sel_chk u_chk (.*);

// File: tb/lane_green_sel_bench.sv
`timescale 1ns/1ps
module lane_green_sel_bench;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic prio_car = 1'b0, left_car = 1'b0, right_car = 1'b0, alt_left = 1'b0;
  logic prio_green, left_green, right_green;

  int checks = 0;
  int failures = 0;
  logic [2:0] last_exp = 3'b000;

  always #2 clk = ~clk;

  lane_green_sel u_lane_green_sel (
    .clk(clk), .rst(rst),
    .prio_car(prio_car), .left_car(left_car), .right_car(right_car), .alt_left(alt_left),
    .prio_green(prio_green), .left_green(left_green), .right_green(right_green)
  );

  function automatic logic [2:0] expect_lights(input logic [3:0] v);
    logic p, l, r, a;
    {a, r, l, p} = v;
    if (p) return 3'b100;
    if (l && !r) return 3'b010;
    if (r && !l) return 3'b001;
    if (l && r) return a ? 3'b010 : 3'b001;
    return 3'b000;
  endfunction

  function automatic string req_of(input logic [3:0] v);
    if (v[0]) return "R2";
    if (v[1] && !v[2]) return "R3";
    if (v[2] && !v[1]) return "R4";
    if (v[1] && v[2]) return "R5";
    return "R7";
  endfunction

  task automatic check(input string req, input logic [2:0] exp);
    logic [2:0] act;
    act = {prio_green, left_green, right_green};
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s lights=%b expected=%b", req, act, exp);
    end
    if ($countones(act) > 1) begin
      failures++;
      $display("FAIL R6 lights=%b expected=at most one green", act);
    end
  endtask

  task automatic drive(input logic [3:0] v);
    @(negedge clk);
    {alt_left, right_car, left_car, prio_car} = v;
  endtask

  task automatic apply_and_check(input logic [3:0] v);
    logic [2:0] e;
    e = expect_lights(v);
    drive(v);
    repeat (2) @(posedge clk);
    #1 check("R8", last_exp);
    @(posedge clk);
    #1 check(req_of(v), e);
    last_exp = e;
  endtask

  task automatic t_reset;
    rst = 1'b1;
    {alt_left, right_car, left_car, prio_car} = 4'b1111;
    repeat (3) @(posedge clk);
    #1 check("R1", 3'b000);
    @(negedge clk);
    rst = 1'b0;
    {alt_left, right_car, left_car, prio_car} = 4'b0000;
    repeat (4) @(posedge clk);
    #1 check("R7", 3'b000);
    last_exp = 3'b000;
  endtask

  task automatic t_all_combos;
    for (int k = 0; k < 16; k++) apply_and_check(4'(k));
    for (int k = 15; k >= 0; k--) apply_and_check(4'(k));
  endtask

  task automatic t_alt_ignored;
    logic [3:0] base [4] = '{4'b0001, 4'b0011, 4'b0101, 4'b0010};
    for (int k = 0; k < 4; k++) begin
      apply_and_check(base[k]);
      drive(base[k] ^ 4'b1000);
      for (int c = 0; c < 4; c++) begin
        @(posedge clk);
        #1 check("R9", last_exp);
      end
      last_exp = expect_lights(base[k] ^ 4'b1000);
    end
    apply_and_check(4'b1111);
    apply_and_check(4'b0111);
    apply_and_check(4'b1110);
    apply_and_check(4'b0110);
  endtask

  task automatic t_reset_in_flight;
    apply_and_check(4'b0001);
    drive(4'b0010);
    rst = 1'b1;
    @(posedge clk);
    #1 check("R1", 3'b000);
    @(negedge clk);
    rst = 1'b0;
    repeat (2) @(posedge clk);
    #1 check("R8", 3'b000);
    @(posedge clk);
    #1 check("R3", 3'b010);
    last_exp = 3'b010;
  endtask

  initial begin
    #(4 * 150000);
    failures++;
    $display("FAIL watchdog lights=%b expected=run complete", {prio_green, left_green, right_green});
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_all_combos();
    t_alt_ignored();
    t_reset_in_flight();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule